// File: doc/BRIEF.md
# Fixed-Point DC Blocking High-Pass Filter

This block strips the constant offset from a stream of unsigned 16-bit audio samples and hands on signed samples centred on zero. It is a single-pole recursive high-pass section that works entirely in integer arithmetic. Each accepted sample is widened into a 32-bit working format that carries four guard bits. The block then forms the first difference of the input plus the previous feedback term. The feedback term for the next sample is that sum multiplied by a fixed coefficient of 1048300, where unity is 2^20. This puts the corner near 2 Hz at a 44.1 kHz rate.

The sample sent downstream is the sum taken before the multiply, not the product. It is scaled back to 16 bits and clipped to a symmetric range. Samples enter with a valid strobe and leave one clock later with their own strobe. A synchronous flush input zeroes the filter history. When a flush coincides with a sample, that sample is filtered against the cleared history.

Top module: `dc_block_hpf`

## Requirements
- R1: An accepted sample `in_data` is zero-extended and multiplied by 16, so the lifted value is x0 = in_data * 16, held as a signed 32-bit number.
- R2: The working sum is acc = x0 + ystate - xstate. The emitted sample is that sum divided by 16 with an arithmetic (floor) shift, then clipped.
- R3: On each accepted sample, ystate becomes floor(acc * 1048300 / 2^20). The product is formed at full 64-bit width before the shift. xstate becomes x0.
- R4: The emitted sample is clipped to the range [-32767, +32767]. The code 16'h8000 (-32768) never appears on `out_data` while `out_valid` is high.
- R5: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and low otherwise. `out_data` holds its previous value while no sample is accepted.
- R6: With `in_valid` low and `flush` low, neither state register changes, so a later sample is filtered as if the gap had not occurred.
- R7: `flush` high with `in_valid` low clears both state registers. The next sample's output therefore equals its own value, clipped to 32767.
- R8: When `flush` and `in_valid` are high in the same cycle, the sample is filtered with both state registers taken as zero. Its output is its own value clipped to 32767, and the state is then loaded from that sample as in R3.
- R9: While `rst_n` is low, `out_valid` is 0, `out_data` is 0 and both state registers are zero.
- R10: Under a constant input, the output magnitude does not grow from one sample to the next, and it decays towards zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous clear of the filter history |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Unsigned input sample |
| out_valid | output | 1 | Output sample strobe, one cycle after the input |
| out_data | output | 16 | Signed, offset-free output sample |

## Verification
A flush and a sample can arrive in the same cycle. The block must then filter the sample against a cleared history rather than drop it or use the stale state. The bench produces this case on directed samples and at random points in the random stream, sometimes back to back with ordinary samples. It judges each one against its own model, which clears the history first and then filters the sample. Assertions also tie the output in that case to the clipped input value. Flushes without a sample are mixed in, and the sample that follows them is checked the same way.

// File: rtl/dcr_pkg.sv
`timescale 1ns/1ps
package dcr_pkg;

  // Fixed feedback coefficient, unity = 2^20 (about 2 Hz corner at 44.1 kHz).
  localparam int unsigned DCR_DEF_COEF = 32'd1048300;

  // Symmetric clip of a wide signed value to +/- lim.
  function automatic logic signed [31:0] dcr_clip(input logic signed [31:0] v,
                                                  input logic signed [31:0] lim);
    logic signed [31:0] r;
    if (v > lim)       r = lim;
    else if (v < -lim) r = -lim;
    else               r = v;
    return r;
  endfunction

endpackage

// File: rtl/dcr_lift.sv
`timescale 1ns/1ps
// Widens an unsigned sample into the signed working format with guard bits.
module dcr_lift #(
  parameter int DATA_W = 16,
  parameter int HEAD_SH = 4,
  parameter int ACC_W = 32
) (
  input  logic [DATA_W-1:0]       smp_i,
  output logic signed [ACC_W-1:0] lifted_o
);
  localparam int PAD_W = ACC_W - DATA_W - HEAD_SH;

  generate
    if (HEAD_SH > 0) begin : g_guard
      assign lifted_o = $signed({{PAD_W{1'b0}}, smp_i, {HEAD_SH{1'b0}}});
    end else begin : g_noguard
      assign lifted_o = $signed({{PAD_W{1'b0}}, smp_i});
    end
  endgenerate
endmodule

// File: rtl/dcr_state.sv
`timescale 1ns/1ps
// Filter history registers: previous lifted input and previous feedback term.
module dcr_state #(
  parameter int ACC_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_i,
  input  logic                    load_i,
  input  logic signed [ACC_W-1:0] x_new_i,
  input  logic signed [ACC_W-1:0] y_new_i,
  output logic signed [ACC_W-1:0] x_prev_o,
  output logic signed [ACC_W-1:0] y_prev_o
);
  logic signed [ACC_W-1:0] x_q, x_d;
  logic signed [ACC_W-1:0] y_q, y_d;
  logic                    en;

  // Clock enable: any accepted sample or clear.
  assign en = load_i | clr_i;

  always_comb begin
    x_d = x_q;
    y_d = y_q;
    if (load_i) begin
      x_d = x_new_i;
      y_d = y_new_i;
    end else if (clr_i) begin
      x_d = '0;
      y_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (en) begin
      x_q <= x_d;
      y_q <= y_d;
    end
  end

  assign x_prev_o = x_q;
  assign y_prev_o = y_q;
endmodule

// File: rtl/dcr_accum.sv
`timescale 1ns/1ps
// Difference-plus-feedback sum; history is masked to zero on a clear.
module dcr_accum #(
  parameter int ACC_W = 32
) (
  input  logic                    clr_i,
  input  logic signed [ACC_W-1:0] x_cur_i,
  input  logic signed [ACC_W-1:0] x_prev_i,
  input  logic signed [ACC_W-1:0] y_prev_i,
  output logic signed [ACC_W-1:0] acc_o
);
  logic signed [ACC_W-1:0] x_hist;
  logic signed [ACC_W-1:0] y_hist;

  always_comb begin
    x_hist = clr_i ? '0 : x_prev_i;
    y_hist = clr_i ? '0 : y_prev_i;
    acc_o  = x_cur_i + y_hist - x_hist;
  end
endmodule

// File: rtl/dcr_fbmul.sv
`timescale 1ns/1ps
// Constant-coefficient fractional multiply for the feedback path.
module dcr_fbmul #(
  parameter int ACC_W = 32,
  parameter int FRAC_SH = 20,
  parameter int unsigned COEF = 32'd1048300
) (
  input  logic signed [ACC_W-1:0] acc_i,
  output logic signed [ACC_W-1:0] y_next_o
);
  localparam int PROD_W = 2 * ACC_W;
  localparam int HI_W   = PROD_W - FRAC_SH - ACC_W;
  localparam logic signed [ACC_W-1:0] COEF_S = ACC_W'(COEF);

  logic signed [PROD_W-1:0] prod;
  logic [HI_W+FRAC_SH-1:0]  prod_unused_bits;

  assign prod     = PROD_W'(acc_i) * PROD_W'(COEF_S);
  assign y_next_o = prod[FRAC_SH +: ACC_W];
  assign prod_unused_bits = {prod[PROD_W-1 -: HI_W], prod[FRAC_SH-1:0]};
endmodule

// File: rtl/dcr_outscale.sv
`timescale 1ns/1ps
// Removes the guard bits and clips symmetrically to the output range.
module dcr_outscale #(
  parameter int DATA_W = 16,
  parameter int HEAD_SH = 4,
  parameter int ACC_W = 32
) (
  input  logic signed [ACC_W-1:0]  acc_i,
  output logic signed [DATA_W-1:0] smp_o
);
  import dcr_pkg::*;
  localparam logic signed [31:0] LIM = 32'(2 ** (DATA_W - 1) - 1);

  logic signed [ACC_W-1:0] scaled;
  logic signed [31:0]      clipped;

  always_comb begin
    scaled  = acc_i >>> HEAD_SH;
    clipped = dcr_clip(32'(scaled), LIM);
    smp_o   = clipped[DATA_W-1:0];
  end

  logic [31-DATA_W:0] clip_unused_hi;
  assign clip_unused_hi = clipped[31:DATA_W];
endmodule

// File: rtl/dc_block_hpf.sv
`timescale 1ns/1ps
module dc_block_hpf #(
  parameter int DATA_W = 16,
  parameter int HEAD_SH = 4,
  parameter int ACC_W = 32,
  parameter int FRAC_SH = 20,
  parameter int unsigned COEF = dcr_pkg::DCR_DEF_COEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic signed [ACC_W-1:0]  x_cur;
  logic signed [ACC_W-1:0]  x1_q;
  logic signed [ACC_W-1:0]  y1_q;
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  y_next;
  logic signed [DATA_W-1:0] smp_out;

  logic              ov_d, ov_q;
  logic [DATA_W-1:0] od_d, od_q;

  dcr_lift #(.DATA_W(DATA_W), .HEAD_SH(HEAD_SH), .ACC_W(ACC_W)) u_lift (
    .smp_i   (in_data),
    .lifted_o(x_cur)
  );

  dcr_accum #(.ACC_W(ACC_W)) u_accum (
    .clr_i   (flush),
    .x_cur_i (x_cur),
    .x_prev_i(x1_q),
    .y_prev_i(y1_q),
    .acc_o   (acc)
  );

  dcr_fbmul #(.ACC_W(ACC_W), .FRAC_SH(FRAC_SH), .COEF(COEF)) u_fbmul (
    .acc_i   (acc),
    .y_next_o(y_next)
  );

  dcr_state #(.ACC_W(ACC_W)) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (flush),
    .load_i  (in_valid),
    .x_new_i (x_cur),
    .y_new_i (y_next),
    .x_prev_o(x1_q),
    .y_prev_o(y1_q)
  );

  dcr_outscale #(.DATA_W(DATA_W), .HEAD_SH(HEAD_SH), .ACC_W(ACC_W)) u_outscale (
    .acc_i(acc),
    .smp_o(smp_out)
  );

  // Output stage: next-state logic
  always_comb begin
    ov_d = in_valid;
    od_d = od_q;
    if (in_valid) od_d = smp_out;
  end

  // Output stage: registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      od_q <= '0;
    end else begin
      ov_q <= ov_d;
      od_q <= od_d;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
endmodule

// File: rtl/dcr_checker.sv
`timescale 1ns/1ps
module dcr_checker #(
  parameter int DATA_W = 16,
  parameter int HEAD_SH = 4,
  parameter int ACC_W = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    flush,
  input logic                    in_valid,
  input logic [DATA_W-1:0]       in_data,
  input logic                    out_valid,
  input logic [DATA_W-1:0]       out_data,
  input logic signed [ACC_W-1:0] st_x1,
  input logic signed [ACC_W-1:0] st_y1
);
  localparam logic [DATA_W-1:0] NEG_FULL = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] POS_LIM  = {1'b0, {(DATA_W-1){1'b1}}};
  localparam int PAD_W = ACC_W - DATA_W - HEAD_SH;

  // R5
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R5
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));
  // R4
  no_neg_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data != NEG_FULL);
  // R6
  state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !flush) |=> ($stable(st_x1) && $stable(st_y1)));
  // R7
  flush_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !in_valid) |=> (st_x1 == '0 && st_y1 == '0));
  // R3
  xload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> st_x1 == $signed({{PAD_W{1'b0}}, $past(in_data), {HEAD_SH{1'b0}}}));
  // R8
  flush_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && in_valid) |=>
      out_data == (($past(in_data) > POS_LIM) ? POS_LIM : $past(in_data)));
endmodule

bind dc_block_hpf dcr_checker #(
  .DATA_W(DATA_W), .HEAD_SH(HEAD_SH), .ACC_W(ACC_W)
) u_dcr_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .flush    (flush),
  .in_valid (in_valid),
  .in_data  (in_data),
  .out_valid(out_valid),
  .out_data (out_data),
  .st_x1    (x1_q),
  .st_y1    (y1_q)
);

// File: tb/dc_block_hpf_bench.sv
`timescale 1ns/1ps
module dc_block_hpf_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush;
  logic        in_valid;
  logic [15:0] in_data;
  logic        out_valid;
  logic [15:0] out_data;

  int checks = 0;
  int errors = 0;
  longint mx1 = 0;
  longint my1 = 0;
  longint last_exp = 0;
  bit saw_hi = 0;
  bit saw_lo = 0;

  always #2.5 clk = ~clk;

  dc_block_hpf u_dc_block_hpf (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic longint clip_ref(input longint v);
    if (v > 32767) return 32767;
    if (v < -32767) return -32767;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Model of one accepted sample (R1, R2, R3, R8).
  function automatic longint model_step(input longint x, input bit fl);
    longint x0, acc, e;
    if (fl) begin mx1 = 0; my1 = 0; end
    x0  = x * 16;
    acc = x0 + my1 - mx1;
    e   = clip_ref(acc >>> 4);
    my1 = (acc * 64'sd1048300) >>> 20;
    mx1 = x0;
    if (e == 32767) saw_hi = 1;
    if (e == -32767) saw_lo = 1;
    return e;
  endfunction

  task automatic send(input int x, input bit fl, input string req, output longint got);
    longint e;
    @(negedge clk);
    in_valid = 1'b1; in_data = x[15:0]; flush = fl;
    e = model_step(x, fl);
    @(posedge clk); #1;
    chk(out_valid === 1'b1, "R5 valid", longint'(out_valid), 1);
    got = longint'($signed(out_data));
    chk(got == e, req, got, e);
    last_exp = e;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; flush = 1'b0;
      @(posedge clk); #1;
      chk(out_valid === 1'b0, "R5 idle valid", longint'(out_valid), 0);
      chk(longint'($signed(out_data)) == last_exp, "R5 hold data",
          longint'($signed(out_data)), last_exp);
    end
  endtask

  task automatic flush_only();
    @(negedge clk);
    in_valid = 1'b0; flush = 1'b1;
    mx1 = 0; my1 = 0;
    @(posedge clk); #1;
    chk(out_valid === 1'b0, "R7 flush no valid", longint'(out_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    longint got, prev_mag, mag;
    bit mono;
    void'($urandom(32'd20231));
    rst_n = 1'b0; flush = 1'b0; in_valid = 1'b0; in_data = '0;
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    chk(out_valid === 1'b0, "R9 reset valid", longint'(out_valid), 0);
    chk(out_data === 16'h0000, "R9 reset data", longint'(out_data), 0);
    @(negedge clk); rst_n = 1'b1;

    // R9: first sample after reset sees zero history
    send(1234, 0, "R9 first after reset", got);
    send(1300, 0, "R2 small step", got);
    idle(3);
    // R6: gap does not disturb state
    send(1300, 0, "R6 after gap", got);

    // R7: flush alone, then a sample equal to its own value
    flush_only();
    send(20000, 0, "R7 first after flush", got);
    chk(got == 20000, "R7 own value", got, 20000);
    // R8: flush together with sample
    send(1000, 0, "R2 normal", got);
    send(30000, 1, "R8 flush with sample", got);
    chk(got == 30000, "R8 own value", got, 30000);
    send(30000, 0, "R3 after combined flush", got);
    // R8 with clipping
    send(50000, 1, "R8 flush clip", got);
    chk(got == 32767, "R4 R8 clip high", got, 32767);

    // R10 decay under constant full-scale input, then R4 low clip
    flush_only();
    send(65535, 0, "R1 full scale", got);
    chk(got == 32767, "R4 clip high", got, 32767);
    mono = 1; prev_mag = 32767;
    for (int i = 0; i < 6000; i++) begin
      send(65535, 0, "R10 constant", got);
      mag = (got < 0) ? -got : got;
      if (mag > prev_mag) mono = 0;
      prev_mag = mag;
    end
    chk(mono, "R10 nonincreasing", longint'(mono), 1);
    chk(prev_mag < 20000, "R10 decayed", prev_mag, 20000);
    send(0, 0, "R4 drop", got);
    chk(got == -32767, "R4 clip low", got, -32767);

    // Alternating steps between 10000 and 58000
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < 882; i++)
        send((s % 2) ? 10000 : 58000, 0, "R2 step", got);
    end

    // Constrained random with gaps and flushes
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 2) flush_only();
      else if (r < 10) idle($urandom_range(1, 3));
      send($urandom_range(0, 65535), ($urandom_range(0, 49) == 0), "R3 random", got);
    end
    idle(2);

    chk(saw_hi, "R4 high clip seen", longint'(saw_hi), 1);
    chk(saw_lo, "R4 low clip seen", longint'(saw_lo), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule